// File: doc/BRIEF.md
# I2C Hot-Insertion Connection Controller

This block decides when a card's I2C segment may be joined to a live backplane I2C segment. After reset, or whenever a supply-good flag is false, it keeps the two segments isolated and ignores all bus activity. Once both supplies are good, it assumes the backplane is in the middle of a transfer. It therefore waits for a STOP condition or a stretch of bus idle on the backplane. At that moment it checks that both card lines are high. Only then does it join the segments and enable the rise-time accelerators.

While joined, the block acts as a transparent wired-AND bridge, with SDA and SCL handled independently. The line inputs are the levels driven by external devices on each side, with the block's own pull-down excluded. Each pull-down output is computed only from the opposite side's external level, so the bridge can never hold a line low through its own drive. All four line inputs pass through a two-flop synchroniser before use. The supply-good flags are already synchronous and are used directly.

Top module: `i2c_hotplug_bridge`

## Requirements
- R1: While `pwr_main_ok` or `pwr_aux_ok` is 0, `linked`, `accel_en` and all four pull-down outputs are 0, whatever the bus lines do.
- R2: If either supply-good flag is 0 at a rising clock edge, `linked`, `accel_en` and all pull-down outputs are 0 from that edge on.
- R3: With supplies good and not yet linked, bus activity on the backplane that contains no STOP and no idle period does not connect. A STOP is a rising edge of the synchronised backplane SDA while the synchronised backplane SCL is high. A STOP allows connection.
- R4: Bus idle qualifies once the synchronised backplane SDA and SCL have both been high for `IDLE_CYCLES` consecutive cycles while waiting. Any low sample on either line restarts the count from zero.
- R5: A qualifying STOP or idle connects only if both synchronised card lines are high in the following cycle. Otherwise the block returns to waiting, and a later rise of the card lines alone does not connect until a new STOP or idle qualifies.
- R6: `linked` and `accel_en` rise on the same edge, are always equal, and stay 1 while both supplies remain good.
- R7: While linked, a low on the card SDA (or SCL) input asserts `bp_sda_pd` (or `bp_scl_pd`). A low on the backplane SDA (or SCL) input asserts `cd_sda_pd` (or `cd_scl_pd`). Each pull-down follows its input with two cycles of synchroniser latency, and SDA and SCL do not affect each other.
- R8: A pull-down output on one side never depends on the input of its own side. A line held low only on its own side leaves that side's pull-down at 0.
- R9: After reset the block is in its lockout state with all outputs 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_main_ok | input | 1 | Main supply above its good threshold |
| pwr_aux_ok | input | 1 | Second supply above its good threshold |
| bp_sda_i | input | 1 | Backplane SDA level from external devices |
| bp_scl_i | input | 1 | Backplane SCL level from external devices |
| cd_sda_i | input | 1 | Card SDA level from external devices |
| cd_scl_i | input | 1 | Card SCL level from external devices |
| linked | output | 1 | Segments joined |
| accel_en | output | 1 | Rise-time accelerator enable |
| bp_sda_pd | output | 1 | Pull backplane SDA low |
| bp_scl_pd | output | 1 | Pull backplane SCL low |
| cd_sda_pd | output | 1 | Pull card SDA low |
| cd_scl_pd | output | 1 | Pull card SCL low |

## Verification
The bench runs SCL clocking with SDA changing only while SCL is low, and checks that no connection happens until a true STOP appears. A design that took any SDA edge as a STOP would join the segments in mid-transfer. One case has the card's SCL held low at the moment of qualification and released shortly afterwards. A design that connected on the card's rise alone would link early. Another case drops SCL for a single cycle partway through an idle period. A counter that did not restart would qualify too soon. Further cases hold each line low on one side only, to catch pull-downs crossed between SDA and SCL and pull-downs driven by their own side. A supply drop taken while a pull-down is active catches any release that lags by more than one edge.

// File: rtl/hp_pkg.sv
package hp_pkg;
  typedef enum logic [1:0] {
    HP_LOCKOUT        = 2'd0,
    HP_WAIT_STOP_IDLE = 2'd1,
    HP_CHECK_CARD     = 2'd2,
    HP_CONNECTED      = 2'd3
  } hp_state_t;

  localparam int unsigned HP_NUM_LINES = 2;
  localparam int unsigned HP_SDA = 0;
  localparam int unsigned HP_SCL = 1;
endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
  parameter int unsigned W = 4,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= {W{RST_VAL}};
      stage2_q <= {W{RST_VAL}};
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;
endmodule

// File: rtl/hp_bus_monitor.sv
module hp_bus_monitor #(
  parameter int unsigned IDLE_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic sda_i,
  input  logic scl_i,
  output logic qualify_o
);
  localparam int unsigned CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYCLES);

  logic          sda_d_q;
  logic [CW-1:0] run_q;
  logic [CW-1:0] run_d;
  logic          run_en;
  logic          both_hi;
  logic          stop_seen;
  logic          idle_seen;

  assign both_hi   = sda_i & scl_i;
  assign stop_seen = sda_i & ~sda_d_q & scl_i;
  assign idle_seen = (run_q == LIMIT);
  assign qualify_o = arm_i & (stop_seen | idle_seen);

  always_comb begin
    run_en = 1'b0;
    run_d  = run_q;
    if (!arm_i || !both_hi) begin
      run_en = 1'b1;
      run_d  = '0;
    end else if (run_q != LIMIT) begin
      run_en = 1'b1;
      run_d  = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_d_q <= 1'b1;
      run_q   <= '0;
    end else begin
      sda_d_q <= sda_i;
      if (run_en) run_q <= run_d;
    end
  end

  AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= LIMIT); // R4
  AST_LOW_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !both_hi |=> (run_q == '0)); // R4
endmodule

// File: rtl/hp_conn_fsm.sv
module hp_conn_fsm
  import hp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pwr_ok_i,
  input  logic      qualify_i,
  input  logic      card_high_i,
  output hp_state_t state_o,
  output logic      linked_o
);
  hp_state_t state_q;
  hp_state_t state_d;

  always_comb begin
    state_d = state_q;
    if (!pwr_ok_i) begin
      state_d = HP_LOCKOUT;
    end else begin
      unique case (state_q)
        HP_LOCKOUT:        state_d = HP_WAIT_STOP_IDLE;
        HP_WAIT_STOP_IDLE: if (qualify_i) state_d = HP_CHECK_CARD;
        HP_CHECK_CARD:     state_d = card_high_i ? HP_CONNECTED : HP_WAIT_STOP_IDLE;
        HP_CONNECTED:      state_d = HP_CONNECTED;
        default:           state_d = HP_LOCKOUT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= HP_LOCKOUT;
    else        state_q <= state_d;
  end

  assign state_o  = state_q;
  assign linked_o = (state_q == HP_CONNECTED);

  AST_PWR_LOSS_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok_i |=> (state_q == HP_LOCKOUT)); // R2
  AST_CHECK_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HP_CHECK_CARD) |-> $past(state_q == HP_WAIT_STOP_IDLE)); // R3
  AST_LINK_AFTER_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(linked_o) |-> $past(state_q == HP_CHECK_CARD && card_high_i)); // R5
  AST_LINK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (linked_o && pwr_ok_i) |=> linked_o); // R6
endmodule

// File: rtl/i2c_hotplug_bridge.sv
module i2c_hotplug_bridge
  import hp_pkg::*;
#(
  parameter int unsigned IDLE_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_main_ok,
  input  logic pwr_aux_ok,
  input  logic bp_sda_i,
  input  logic bp_scl_i,
  input  logic cd_sda_i,
  input  logic cd_scl_i,
  output logic linked,
  output logic accel_en,
  output logic bp_sda_pd,
  output logic bp_scl_pd,
  output logic cd_sda_pd,
  output logic cd_scl_pd
);
  localparam int unsigned NL = HP_NUM_LINES;

  logic [2*NL-1:0] raw_lines;
  logic [2*NL-1:0] syn_lines;
  logic [NL-1:0]   bp_s;
  logic [NL-1:0]   cd_s;
  logic [NL-1:0]   bp_pd;
  logic [NL-1:0]   cd_pd;
  logic            pwr_ok;
  logic            qualify;
  logic            link_int;
  hp_state_t       state;

  assign pwr_ok    = pwr_main_ok & pwr_aux_ok;
  assign raw_lines = {cd_scl_i, cd_sda_i, bp_scl_i, bp_sda_i};
  assign bp_s      = syn_lines[NL-1:0];
  assign cd_s      = syn_lines[2*NL-1:NL];

  hp_sync #(.W(2*NL), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_lines),
    .q_o   (syn_lines)
  );

  hp_bus_monitor #(.IDLE_CYCLES(IDLE_CYCLES)) u_mon (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_i     (state == HP_WAIT_STOP_IDLE),
    .sda_i     (bp_s[HP_SDA]),
    .scl_i     (bp_s[HP_SCL]),
    .qualify_o (qualify)
  );

  hp_conn_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_ok_i    (pwr_ok),
    .qualify_i   (qualify),
    .card_high_i (&cd_s),
    .state_o     (state),
    .linked_o    (link_int)
  );

  // Each side's pull-down follows only the other side's external level.
  for (genvar i = 0; i < NL; i++) begin : g_line
    assign bp_pd[i] = link_int & ~cd_s[i];
    assign cd_pd[i] = link_int & ~bp_s[i];
  end

  assign linked    = link_int;
  assign accel_en  = link_int;
  assign bp_sda_pd = bp_pd[HP_SDA];
  assign bp_scl_pd = bp_pd[HP_SCL];
  assign cd_sda_pd = cd_pd[HP_SDA];
  assign cd_scl_pd = cd_pd[HP_SCL];

  AST_BP_SDA_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    bp_sda_pd |-> !$past(cd_sda_i, 2)); // R8
  AST_CD_SCL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    cd_scl_pd |-> !$past(bp_scl_i, 2)); // R8
  AST_QUIET_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> !(linked | bp_sda_pd | bp_scl_pd | cd_sda_pd | cd_scl_pd)); // R1
endmodule

// File: tb/i2c_hotplug_bridge_test.sv
module i2c_hotplug_bridge_test;
  localparam int IDLE = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pm = 1'b0, pa = 1'b0;
  logic bsda = 1'b1, bscl = 1'b1, csda = 1'b1, cscl = 1'b1;
  logic linked, accel_en, bp_sda_pd, bp_scl_pd, cd_sda_pd, cd_scl_pd;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  i2c_hotplug_bridge #(.IDLE_CYCLES(IDLE)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_main_ok(pm), .pwr_aux_ok(pa),
    .bp_sda_i(bsda), .bp_scl_i(bscl), .cd_sda_i(csda), .cd_scl_i(cscl),
    .linked(linked), .accel_en(accel_en),
    .bp_sda_pd(bp_sda_pd), .bp_scl_pd(bp_scl_pd),
    .cd_sda_pd(cd_sda_pd), .cd_scl_pd(cd_scl_pd)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%b expected=%b", tag, cyc, act, exp);
    end
  endtask

  // Reference model: mode 0 off, 1 waiting, 2 checking card, 3 joined.
  // Bit order of the history entries: 3 bp_sda, 2 bp_scl, 1 cd_sda, 0 cd_scl.
  int mode = 0;
  int run = 0;
  logic [3:0] hist[$];

  function automatic logic [3:0] seen(input int age);
    if (hist.size() > age) return hist[age];
    return 4'hF;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode = 0; run = 0; hist.delete();
    end else begin
      logic [3:0] now, prev;
      bit stop, idle, qual;
      int nmode, nrun;
      cyc++;
      now  = seen(1);
      prev = seen(2);
      stop = now[3] && !prev[3] && now[2];
      idle = (run == IDLE);
      qual = (mode == 1) && (stop || idle);
      if (mode != 1 || !(now[3] && now[2])) nrun = 0;
      else nrun = (run < IDLE) ? run + 1 : run;
      if (!(pm && pa)) nmode = 0;
      else if (mode == 0) nmode = 1;
      else if (mode == 1) nmode = qual ? 2 : 1;
      else if (mode == 2) nmode = (now[1] && now[0]) ? 3 : 1;
      else nmode = 3;
      mode = nmode; run = nrun;
      hist.push_front({bsda, bscl, csda, cscl});
      if (hist.size() > 4) void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] s;
      logic lk;
      s  = seen(1);
      lk = (mode == 3);
      chk("R6 linked vs model", linked, lk);
      chk("R6 accel_en vs model", accel_en, lk);
      chk("R7 bp_sda_pd vs model", bp_sda_pd, lk & ~s[1]);
      chk("R7 bp_scl_pd vs model", bp_scl_pd, lk & ~s[0]);
      chk("R7 cd_sda_pd vs model", cd_sda_pd, lk & ~s[3]);
      chk("R7 cd_scl_pd vs model", cd_scl_pd, lk & ~s[2]);
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired at cycle %0d: actual=running expected=finished", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_n(3);
    chk("R9 linked in reset", linked, 1'b0);
    rst_n = 1'b1;
    wait_n(1);
    chk("R9 linked after reset", linked, 1'b0);
    chk("R9 bp_sda_pd after reset", bp_sda_pd, 1'b0);

    // R1: unpowered, quiet bus and card lines pulled low
    wait_n(2 * IDLE);
    csda = 1'b0; bsda = 1'b0;
    wait_n(5);
    chk("R1 no link unpowered", linked, 1'b0);
    chk("R1 no bp pull-down unpowered", bp_sda_pd, 1'b0);
    chk("R1 no cd pull-down unpowered", cd_sda_pd, 1'b0);
    csda = 1'b1; bsda = 1'b1; pa = 1'b1;
    wait_n(2 * IDLE);
    chk("R1 one supply only", linked, 1'b0);

    // R3: transfer in progress, SDA changes only with SCL low
    pm = 1'b1;
    bscl = 1'b0; bsda = 1'b0;
    for (int k = 0; k < 12; k++) begin
      bsda = k[0]; wait_n(1);
      bscl = 1'b1; wait_n(2);
      bscl = 1'b0; wait_n(1);
    end
    bsda = 1'b0; wait_n(1);
    chk("R3 no link without STOP", linked, 1'b0);
    bscl = 1'b1; wait_n(2);
    bsda = 1'b1; wait_n(6);
    chk("R3 link after STOP", linked, 1'b1);
    chk("R6 accel with link", accel_en, 1'b1);

    // R7/R8: wired-AND per line
    csda = 1'b0; wait_n(3);
    chk("R7 card SDA low pulls backplane", bp_sda_pd, 1'b1);
    chk("R8 card SDA own side idle", cd_sda_pd, 1'b0);
    chk("R7 SCL untouched by SDA", bp_scl_pd, 1'b0);
    csda = 1'b1; bscl = 1'b0; wait_n(3);
    chk("R7 SDA released", bp_sda_pd, 1'b0);
    chk("R7 backplane SCL low pulls card", cd_scl_pd, 1'b1);
    chk("R8 backplane SCL own side idle", bp_scl_pd, 1'b0);
    cscl = 1'b0; wait_n(3);
    chk("R7 both SCL sides low", bp_scl_pd, 1'b1);
    bscl = 1'b1; cscl = 1'b1; wait_n(3);
    chk("R7 SCL released", cd_scl_pd, 1'b0);

    // R2: supply drop while a pull-down is active
    csda = 1'b0; wait_n(3);
    chk("R2 pre-drop pull-down", bp_sda_pd, 1'b1);
    pa = 1'b0; wait_n(1);
    chk("R2 link dropped in one clock", linked, 1'b0);
    chk("R2 accel dropped", accel_en, 1'b0);
    chk("R2 pull-down released", bp_sda_pd, 1'b0);
    csda = 1'b1; wait_n(3);

    // R5: card SCL low at qualification, rises later
    cscl = 1'b0; pa = 1'b1;
    wait_n(IDLE + 10);
    cscl = 1'b1;
    wait_n(10);
    chk("R5 card rise alone does not link", linked, 1'b0);
    wait_n(IDLE);
    chk("R5 links on next idle", linked, 1'b1);

    // R4: idle count restarts on a short SCL low
    pm = 1'b0; wait_n(2);
    pm = 1'b1; wait_n(12);
    bscl = 1'b0; wait_n(1);
    bscl = 1'b1; wait_n(15);
    chk("R4 interrupted idle does not link", linked, 1'b0);
    wait_n(15);
    chk("R4 full idle links", linked, 1'b1);

    wait_n(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule